// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs the word-at-a-time programming flow of a serial flash slave. A separate SPI front-end delivers whole bytes together with one-cycle pulses marking the start and the end of each chip-select window. The sequencer decodes the opcode in the first byte of a window and collects the address and data bytes that follow it. When the window closes with a complete command, it issues a two-byte program request to the array model. It also times the self-timed busy period and keeps the write-enable and auto-increment status flags.

The flow opens with a start command that carries an address and two data bytes. After that, each continuation command carries two data bytes and no address, and it targets the next even word. The flow closes on a write-disable command. It also closes by itself when the next word would fall into the protected region, because the address does not wrap. While the flow is active, only a small set of opcodes has any effect. An optional mode turns the serial output into a ready/busy line whenever chip-select is low during the flow.

Top module: `aai_word_seq`

## Requirements
- R1: After reset, stat_busy, stat_wel, stat_aai, so_oe and prog_req are all 0.
- R2: Outside the flow, a window holding exactly the single byte 06h sets stat_wel. A window holding exactly the single byte 04h clears stat_wel at any time.
- R3: A start window is made of opcode ADh, three address bytes sent MSB first (the low ADDR_W bits are used), and two data bytes. It is accepted when stat_wel=1, the block is not busy, and the word address is below prot_lo. The word address is the received address with bit 0 cleared. When accepted, prog_req pulses for one cycle, on the cycle after cs_end, with prog_addr set to that word address and prog_d0/prog_d1 set to the first and second data bytes. stat_aai is set at the same time.
- R4: A start window is ignored when stat_wel=0, or when its word address is greater than or equal to prot_lo.
- R5: During the flow, a continuation window (ADh followed by two data bytes) requests the previous word address plus 2.
- R6: A window that closes with a byte count other than the exact count of its command is discarded: there is no request and the word address does not advance.
- R7: stat_busy is high for exactly BUSY_CYC cycles, starting on the cycle of prog_req. A program window that closes while stat_busy=1 is ignored.
- R8: During the flow, the opcodes 06h, 70h and 80h have no effect.
- R9: During the flow, the window 04h clears both stat_aai and stat_wel.
- R10: When busy ends and the last programmed word address plus 2 is greater than or equal to prot_lo, stat_aai and stat_wel clear together. The address does not wrap, and later continuation windows produce no request.
- R11: Outside the flow, the window 70h enables ready/busy output and 80h disables it. While it is enabled and stat_aai=1 and cs_n=0, so_oe=1 and so_val is 0 when busy and 1 when ready. Otherwise so_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cs_n | input | 1 | chip-select level, low = selected |
| cs_start | input | 1 | one-cycle pulse when a window opens |
| cs_end | input | 1 | one-cycle pulse when a window closes |
| byte_vld | input | 1 | a received byte is valid |
| byte_dat | input | 8 | received byte |
| prot_lo | input | ADDR_W+1 | lowest protected address; 2^ADDR_W means nothing is protected |
| prog_req | output | 1 | program request pulse to the array |
| prog_addr | output | ADDR_W | even address of the word being programmed |
| prog_d0 | output | 8 | byte for the even address |
| prog_d1 | output | 8 | byte for the odd address |
| stat_busy | output | 1 | program in progress |
| stat_wel | output | 1 | write-enable latch |
| stat_aai | output | 1 | auto-increment flow active |
| so_oe | output | 1 | serial output driven by ready/busy |
| so_val | output | 1 | ready/busy level, 1 = ready |

## Verification
The hardest case to reach is the automatic exit at the top of the unprotected space. It needs an accepted start, a full busy period, and an address that lands exactly one word below the protection boundary. The stimulus gets there by lowering prot_lo to a small even value and starting two words below it, so that the exit comes after one continuation. A second run starts on the last word of the whole address space with nothing protected, which shows that the address does not wrap. Ready/busy output is checked by lowering cs_n while a program is still counting down, and then again after the busy period has ended.

// File: rtl/aai_word_seq.sv
module aai_word_seq #(
  parameter int ADDR_W   = 20,
  parameter int BUSY_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic [ADDR_W:0]   prot_lo,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_d0,
  output logic [7:0]        prog_d1,
  output logic              stat_busy,
  output logic              stat_wel,
  output logic              stat_aai,
  output logic              so_oe,
  output logic              so_val
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [7:0] OP_WORD = 8'hAD, OP_WEN = 8'h06, OP_WDIS = 8'h04,
                         OP_RBON = 8'h70, OP_RBOFF = 8'h80;

  logic [7:0]        op, d0, d1;
  logic [2:0]        bcnt;
  logic [ADDR_W-1:0] a_sh, wa;
  logic [CW-1:0]     cnt;
  logic              hw_en;

  wire single = cs_end && bcnt == 3'd1;
  wire [ADDR_W-1:0] start_word = {a_sh[ADDR_W-1:1], 1'b0};
  wire [ADDR_W:0]   next_ext   = {1'b0, wa} + (ADDR_W+1)'(2);

  wire do_wen   = single && op == OP_WEN && !stat_aai;
  wire do_wdis  = single && op == OP_WDIS;
  wire do_rbon  = single && op == OP_RBON && !stat_aai;
  wire do_rboff = single && op == OP_RBOFF && !stat_aai;
  wire do_first = cs_end && !stat_aai && !stat_busy && op == OP_WORD && bcnt == 3'd6
                  && stat_wel && ({1'b0, start_word} < prot_lo);
  wire do_next  = cs_end && stat_aai && !stat_busy && op == OP_WORD && bcnt == 3'd3
                  && (next_ext < prot_lo);
  wire done     = cnt == CW'(1);
  wire top_exit = done && stat_aai && (next_ext >= prot_lo);

  assign stat_busy = cnt != '0;
  assign so_oe     = hw_en && stat_aai && !cs_n;
  assign so_val    = !stat_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op <= '0; bcnt <= '0; a_sh <= '0; d0 <= '0; d1 <= '0;
    end else if (cs_start) begin
      op <= '0; bcnt <= '0;
    end else if (byte_vld) begin
      if (bcnt == 3'd0) op <= byte_dat;
      else if (op == OP_WORD && !stat_aai) begin
        if (bcnt <= 3'd3) a_sh <= {a_sh[ADDR_W-9:0], byte_dat};
        else if (bcnt == 3'd4) d0 <= byte_dat;
        else if (bcnt == 3'd5) d1 <= byte_dat;
      end else if (op == OP_WORD) begin
        if (bcnt == 3'd1) d0 <= byte_dat;
        else if (bcnt == 3'd2) d1 <= byte_dat;
      end
      if (bcnt != 3'd7) bcnt <= bcnt + 3'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_wel <= 1'b0; stat_aai <= 1'b0; hw_en <= 1'b0;
      prog_req <= 1'b0; prog_addr <= '0; prog_d0 <= '0; prog_d1 <= '0;
      wa <= '0; cnt <= '0;
    end else begin
      prog_req <= do_first || do_next;
      if (do_first || do_next) begin
        prog_addr <= do_first ? start_word : next_ext[ADDR_W-1:0];
        wa        <= do_first ? start_word : next_ext[ADDR_W-1:0];
        prog_d0   <= d0;
        prog_d1   <= d1;
        cnt       <= CW'(BUSY_CYC);
      end else if (stat_busy) cnt <= cnt - CW'(1);
      if (do_wen) stat_wel <= 1'b1;
      else if (do_wdis || top_exit) stat_wel <= 1'b0;
      if (do_first) stat_aai <= 1'b1;
      else if (do_wdis || top_exit) stat_aai <= 1'b0;
      if (do_rbon) hw_en <= 1'b1;
      else if (do_rboff) hw_en <= 1'b0;
    end

  // R3
  aai_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_aai) |-> prog_req);
  // R4
  req_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> stat_wel);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && $past(stat_aai) |-> prog_addr == $past(prog_addr) + ADDR_W'(2));
  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !$past(stat_busy));
  // R10
  exit_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_aai) |-> !stat_wel);
endmodule

// File: tb/test_aai_word_seq.sv
module test_aai_word_seq;
  localparam int AW = 20;
  localparam int BC = 30;

  logic clk = 0, rst_n = 0, cs_n = 1, cs_start = 0, cs_end = 0, byte_vld = 0;
  logic [7:0] byte_dat = '0;
  logic [AW:0] prot_lo = 21'h100000;
  logic prog_req, stat_busy, stat_wel, stat_aai, so_oe, so_val;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_d0, prog_d1;

  aai_word_seq #(.ADDR_W(AW), .BUSY_CYC(BC)) i_aai_word_seq (
    .clk, .rst_n, .cs_n, .cs_start, .cs_end, .byte_vld, .byte_dat, .prot_lo,
    .prog_req, .prog_addr, .prog_d0, .prog_d1, .stat_busy, .stat_wel,
    .stat_aai, .so_oe, .so_val);

  always #2 clk = ~clk;

  int total = 0, bad = 0, nreq = 0, blen = 0;
  logic [AW-1:0] last_addr = '0;
  logic [7:0] last_d0 = '0;

  always @(negedge clk) begin
    if (prog_req) begin nreq++; last_addr = prog_addr; last_d0 = prog_d0; blen = 1; end
    else if (stat_busy) blen++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input int len, input logic [47:0] b);
    @(negedge clk) cs_n = 0; cs_start = 1;
    @(negedge clk) cs_start = 0;
    for (int i = 0; i < len; i++) begin
      byte_vld = 1; byte_dat = b[47-8*i -: 8];
      @(negedge clk) byte_vld = 0;
      @(negedge clk);
    end
    cs_n = 1; cs_end = 1;
    @(negedge clk) cs_end = 0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (stat_busy);
    @(negedge clk);
  endtask

  // len[81:79] bytes[78:31] req[30] addr[29:10] d0[9:2] aai[1] wel[0]
  localparam logic [81:0] TBL [11] = '{
    {3'd1, 48'h060000000000, 1'b0, 20'h00000, 8'h00, 1'b0, 1'b1},
    {3'd6, 48'hAD000123A55A, 1'b1, 20'h00122, 8'hA5, 1'b1, 1'b1},
    {3'd3, 48'hAD1122000000, 1'b1, 20'h00124, 8'h11, 1'b1, 1'b1},
    {3'd1, 48'h060000000000, 1'b0, 20'h00124, 8'h11, 1'b1, 1'b1},
    {3'd3, 48'hAD3344000000, 1'b1, 20'h00126, 8'h33, 1'b1, 1'b1},
    {3'd1, 48'h050000000000, 1'b0, 20'h00126, 8'h33, 1'b1, 1'b1},
    {3'd1, 48'h040000000000, 1'b0, 20'h00126, 8'h33, 1'b0, 1'b0},
    {3'd6, 48'hAD0002007788, 1'b0, 20'h00126, 8'h33, 1'b0, 1'b0},
    {3'd1, 48'h060000000000, 1'b0, 20'h00126, 8'h33, 1'b0, 1'b1},
    {3'd6, 48'hAD0F000199AA, 1'b1, 20'hF0000, 8'h99, 1'b1, 1'b1},
    {3'd1, 48'h040000000000, 1'b0, 20'hF0000, 8'h99, 1'b0, 1'b0}
  };

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", stat_busy, 0); chk("R1 wel", stat_wel, 0);
    chk("R1 aai", stat_aai, 0);   chk("R1 so_oe", so_oe, 0);
    chk("R1 req", prog_req, 0);
    rst_n = 1;
    @(negedge clk);

    // table: R2 R3 R4 R5 R8 R9
    foreach (TBL[k]) begin
      n0 = nreq;
      xact(int'(TBL[k][81:79]), TBL[k][78:31]);
      wait_idle();
      chk($sformatf("R2/R3/R4/R5/R8/R9 row%0d req", k), nreq - n0, TBL[k][30]);
      chk($sformatf("R3/R5 row%0d addr", k), last_addr, TBL[k][29:10]);
      chk($sformatf("R3/R5 row%0d d0", k), last_d0, TBL[k][9:2]);
      chk($sformatf("R8/R9 row%0d aai", k), stat_aai, TBL[k][1]);
      chk($sformatf("R2/R9 row%0d wel", k), stat_wel, TBL[k][0]);
    end

    // R6 early close on start and continuation
    xact(1, 48'h06 << 40);
    n0 = nreq;
    xact(5, 48'hAD00020011 << 8);
    wait_idle();
    chk("R6 short start req", nreq - n0, 0);
    chk("R6 short start aai", stat_aai, 0);
    xact(6, 48'hAD0002005566);
    wait_idle();
    chk("R7 busy length", blen, BC);
    chk("R3 d1", prog_d1, 8'h66);
    n0 = nreq;
    xact(2, 48'hAD55 << 32);
    wait_idle();
    chk("R6 short next req", nreq - n0, 0);
    // R7 command while busy ignored
    xact(3, 48'hAD0102 << 24);
    xact(3, 48'hAD0304 << 24);
    wait_idle();
    chk("R7 busy ignore cnt", nreq - n0, 1);
    chk("R6/R7 addr no extra advance", last_addr, 20'h00202);
    xact(3, 48'hAD0506 << 24);
    wait_idle();
    chk("R5 addr after ignored", last_addr, 20'h00204);
    xact(1, 48'h04 << 40);

    // R11 ready/busy output
    xact(1, 48'h70 << 40);
    xact(1, 48'h06 << 40);
    xact(6, 48'hAD000400A1A2);
    @(negedge clk) cs_n = 0;
    @(negedge clk);
    chk("R11 oe busy", so_oe, 1); chk("R11 val busy", so_val, 0);
    cs_n = 1;
    @(negedge clk);
    chk("R11 oe cs high", so_oe, 0);
    wait_idle();
    cs_n = 0;
    @(negedge clk);
    chk("R11 val ready", so_val, 1);
    cs_n = 1;
    xact(1, 48'h80 << 40);
    @(negedge clk) cs_n = 0;
    @(negedge clk);
    chk("R8 80h ignored in flow", so_oe, 1);
    cs_n = 1;
    xact(1, 48'h04 << 40);
    @(negedge clk) cs_n = 0;
    @(negedge clk);
    chk("R11 oe after exit", so_oe, 0);
    cs_n = 1;
    xact(1, 48'h80 << 40);
    xact(1, 48'h06 << 40);
    xact(6, 48'hAD000600B1B2);
    @(negedge clk) cs_n = 0;
    @(negedge clk);
    chk("R11 disabled", so_oe, 0);
    cs_n = 1;
    wait_idle();
    xact(1, 48'h04 << 40);
    // R8 70h inside flow ignored
    xact(1, 48'h06 << 40);
    xact(6, 48'hAD000800C1C2);
    xact(1, 48'h70 << 40);
    wait_idle();
    cs_n = 0;
    @(negedge clk);
    chk("R8 70h ignored in flow", so_oe, 0);
    cs_n = 1;
    xact(1, 48'h04 << 40);

    // R10 exit at protection boundary
    prot_lo = 21'h000008;
    xact(1, 48'h06 << 40);
    xact(6, 48'hAD000004D1D2);
    wait_idle();
    chk("R10 addr start", last_addr, 20'h00004);
    chk("R10 aai still on", stat_aai, 1);
    xact(3, 48'hADE1E2 << 24);
    wait_idle();
    chk("R10 addr last", last_addr, 20'h00006);
    chk("R10 aai off", stat_aai, 0); chk("R10 wel off", stat_wel, 0);
    n0 = nreq;
    xact(3, 48'hADF1F2 << 24);
    wait_idle();
    chk("R10 no wrap req", nreq - n0, 0);
    // R4 protected start
    xact(1, 48'h06 << 40);
    xact(6, 48'hAD0000081234);
    wait_idle();
    chk("R4 protected req", nreq - n0, 0);
    chk("R4 protected aai", stat_aai, 0);
    chk("R4 protected wel", stat_wel, 1);
    // R10 top of space
    prot_lo = 21'h100000;
    xact(6, 48'hAD0FFFFF5A5A);
    wait_idle();
    chk("R10 top addr", last_addr, 20'hFFFFE);
    chk("R10 top aai", stat_aai, 0);
    chk("R10 top wel", stat_wel, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule